// File: doc/BRIEF.md
# Serial Memory Word Address Pointer

This block holds the word address for a 32K x 8 serial memory. The bus front end delivers the target address as two bytes, high byte first. The high byte is parked in a staging register. The pointer only changes when the low byte arrives, and at that point both halves take effect together. Between transactions the pointer keeps its value. This lets a current-address read pick up where the last access stopped, and lets an address loaded by a write header survive a repeated START into a read header.

The pointer advances in two ways. A read advance steps the whole address and rolls over from the top of the array to zero. A write advance steps only the in-page bits and leaves the page number alone, so a long page write folds back onto the start of its page. Bus decoding, acknowledge handling and storage are done elsewhere.

Top module: `ser_mem_addr_ptr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `addr_o` is 0 and the staged high byte is 0.
- R2: A `ld_hi_i` strobe that has no other strobe with it leaves `addr_o` unchanged.
- R3: A `ld_lo_i` strobe sets `addr_o`, one clock later, to {staged high byte bits 6:0, `byte_i`}. Bit 7 of the high byte is ignored.
- R4: A `rd_adv_i` pulse sets `addr_o` to `addr_o`+1 one clock later. It wraps from 0x7FFF to 0x0000.
- R5: A `wr_adv_i` pulse steps `addr_o[5:0]` by one modulo 64 and keeps `addr_o[14:6]`. For example, 0x7FFF becomes 0x7FC0.
- R6: With no strobe, `addr_o` holds its value for any number of cycles.
- R7: When strobes coincide, the priority is `ld_lo_i` first, then `rd_adv_i`, then `wr_adv_i`.
- R8: A `ld_hi_i` given in the same cycle as `ld_lo_i` is ignored. The load uses the previously staged byte, and the staged byte is not changed.
- R9: The staged high byte is kept until the next accepted `ld_hi_i`. Later `ld_lo_i` strobes reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_hi_i | input | 1 | Stage `byte_i` as the high address byte |
| ld_lo_i | input | 1 | Load pointer from staged high byte and `byte_i` |
| byte_i | input | 8 | Address byte from the bus front end |
| rd_adv_i | input | 1 | Advance after a read byte (full-array wrap) |
| wr_adv_i | input | 1 | Advance after a written byte (in-page wrap) |
| addr_o | output | 15 | Current word address |

## Verification
The bench targets three boundaries:
- The read rollover at 0x7FFF. A design that limits reads to the page would return 0x7FC0 here instead of 0.
- The page boundary on write advance. A design that lets the carry ripple would move into the next page, for example 0x01BF to 0x01C0 instead of 0x0180.
- Sixty-four consecutive write advances, which must land back on the starting address.

Coinciding strobes are also exercised, which exposes a wrong priority order. A high byte masked by a simultaneous low load is checked too: a design that still captures it shows a different address on the following bare low load. Loading only the high byte must not disturb the pointer, and bit 7 of the high byte must never reach the address.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
  // which rule moves the pointer this cycle
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_READ = 2'd2,
    STEP_PAGE = 2'd3
  } step_e;
endpackage

// File: rtl/aptr_hi_stage.sv
module aptr_hi_stage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] stage_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stage_o <= '0;
    else if (take_i) stage_o <= byte_i;
  end
endmodule

// File: rtl/aptr_next.sv
module aptr_next
  import aptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [BYTE_W-1:0] stage_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ld_lo_i,
  input  logic              rd_adv_i,
  input  logic              wr_adv_i,
  output step_e             step_o,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int unsigned HI_W   = ADDR_W - BYTE_W;
  localparam int unsigned DROP_W = 2*BYTE_W - ADDR_W;

  // full-array step: natural rollover at the array size
  function automatic logic [ADDR_W-1:0] read_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] page_val;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_val = read_step(cur_i);
    end else begin : g_paged
      function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] low;
        low = a[PAGE_W-1:0] + PAGE_W'(1);
        return {a[ADDR_W-1:PAGE_W], low};
      endfunction
      assign page_val = page_step(cur_i);
    end
  endgenerate

  logic [HI_W-1:0]   hi_keep;
  logic [DROP_W-1:0] hi_dropped_unused;
  assign hi_keep           = stage_i[HI_W-1:0];
  assign hi_dropped_unused = stage_i[BYTE_W-1:HI_W];

  always_comb begin
    if (ld_lo_i)       step_o = STEP_LOAD;
    else if (rd_adv_i) step_o = STEP_READ;
    else if (wr_adv_i) step_o = STEP_PAGE;
    else               step_o = STEP_HOLD;
  end

  always_comb begin
    unique case (step_o)
      STEP_LOAD: nxt_o = {hi_keep, byte_i};
      STEP_READ: nxt_o = read_step(cur_i);
      STEP_PAGE: nxt_o = page_val;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/aptr_reg.sv
module aptr_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] cur_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_o <= '0;
    else        cur_o <= nxt_i;
  end
endmodule

// File: rtl/ser_mem_addr_ptr.sv
module ser_mem_addr_ptr
  import aptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_adv_i,
  input  logic              wr_adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  // named internal events
  logic              stage_take;
  logic [BYTE_W-1:0] stage_q;
  logic [ADDR_W-1:0] addr_nxt;
  step_e             step;

  // a high byte arriving with a low-byte load is dropped
  assign stage_take = ld_hi_i && !ld_lo_i;

  aptr_hi_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (stage_take),
    .byte_i  (byte_i),
    .stage_o (stage_q)
  );

  aptr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_next (
    .cur_i    (addr_o),
    .stage_i  (stage_q),
    .byte_i   (byte_i),
    .ld_lo_i  (ld_lo_i),
    .rd_adv_i (rd_adv_i),
    .wr_adv_i (wr_adv_i),
    .step_o   (step),
    .nxt_o    (addr_nxt)
  );

  aptr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt_i (addr_nxt),
    .cur_o (addr_o)
  );
endmodule

// File: rtl/ser_mem_addr_ptr_chk.sv
module ser_mem_addr_ptr_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_hi_i,
  input logic              ld_lo_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              rd_adv_i,
  input logic              wr_adv_i,
  input logic [ADDR_W-1:0] addr_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> addr_o == '0);

  // R2
  hi_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi_i && !ld_lo_i && !rd_adv_i && !wr_adv_i) |=> $stable(addr_o));

  // R3
  lo_load_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> addr_o[BYTE_W-1:0] == $past(byte_i));

  // R4 R7
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_i && !ld_lo_i) |=> addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

  // R5
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv_i && !rd_adv_i && !ld_lo_i) |=>
      addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

  // R5
  page_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv_i && !rd_adv_i && !ld_lo_i) |=>
      addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + PAGE_W'(1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_hi_i && !ld_lo_i && !rd_adv_i && !wr_adv_i) |=> $stable(addr_o));
endmodule

bind ser_mem_addr_ptr ser_mem_addr_ptr_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
  .byte_i(byte_i), .rd_adv_i(rd_adv_i), .wr_adv_i(wr_adv_i), .addr_o(addr_o)
);

// File: tb/ser_mem_addr_ptr_test.sv
module ser_mem_addr_ptr_test;
  localparam int CLK_P = 10;
  localparam int NV    = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_hi, ld_lo, rd_adv, wr_adv;
  logic [7:0]  byte_v;
  logic [14:0] addr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ser_mem_addr_ptr uut (
    .clk(clk), .rst_n(rst_n), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo),
    .byte_i(byte_v), .rd_adv_i(rd_adv), .wr_adv_i(wr_adv), .addr_o(addr)
  );

  // {ld_hi, ld_lo, rd, wr, byte, expected address (16 bits)}
  localparam logic [27:0] VEC [0:NV-1] = '{
    {4'b1000, 8'h12, 16'h0000},
    {4'b0100, 8'h34, 16'h1234},
    {4'b0010, 8'h00, 16'h1235},
    {4'b0001, 8'h00, 16'h1236},
    {4'b1000, 8'h7F, 16'h1236},
    {4'b0100, 8'hFF, 16'h7FFF},
    {4'b0010, 8'h00, 16'h0000},
    {4'b1000, 8'h81, 16'h0000},
    {4'b0100, 8'hBF, 16'h01BF},
    {4'b0001, 8'h00, 16'h0180},
    {4'b0000, 8'h00, 16'h0180},
    {4'b0100, 8'h00, 16'h0100},
    {4'b0110, 8'h05, 16'h0105},
    {4'b0011, 8'h00, 16'h0106},
    {4'b1100, 8'h22, 16'h0122},
    {4'b0100, 8'h33, 16'h0133},
    {4'b1000, 8'hFF, 16'h0133},
    {4'b0100, 8'hFF, 16'h7FFF},
    {4'b0001, 8'h00, 16'h7FC0}
  };

  function automatic string tag_of(input logic [3:0] s);
    if (s[2]) return (s[1] || s[0]) ? "R7" : (s[3] ? "R8" : "R3");
    if (s[1]) return s[0] ? "R7" : "R4";
    if (s[0]) return "R5";
    if (s[3]) return "R2";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [14:0] exp);
    n_chk++;
    if (addr !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, addr, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, come back to a negedge
  task automatic step(input logic [3:0] s, input logic [7:0] b);
    {ld_hi, ld_lo, rd_adv, wr_adv} = s;
    byte_v = b;
    @(posedge clk);
    @(negedge clk);
    {ld_hi, ld_lo, rd_adv, wr_adv} = 4'b0000;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    {ld_hi, ld_lo, rd_adv, wr_adv} = 4'b0000;
    byte_v = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", 15'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 15'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27:24], VEC[i][23:16]);
      check(tag_of(VEC[i][27:24]), VEC[i][14:0]);
    end

    // R6: long idle keeps the pointer
    repeat (50) @(negedge clk);
    check("R6", 15'h7FC0);

    // R5: 64 write advances fold back to the start of the page
    step(4'b1000, 8'h2A);
    step(4'b0100, 8'h95);
    check("R3", 15'h2A95);
    for (int k = 0; k < 64; k++) step(4'b0001, 8'h00);
    check("R5", 15'h2A95);

    // R9: staged high byte reused by later bare low loads
    step(4'b0100, 8'h01);
    check("R9", 15'h2A01);
    step(4'b0010, 8'h00);
    step(4'b0100, 8'hEE);
    check("R9", 15'h2AEE);

    // R1: mid-run reset clears pointer and staged byte
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 15'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    step(4'b0100, 8'h44);
    check("R1", 15'h0044);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule